// File: doc/BRIEF.md
# Breaking-Event Address Tracker

This block records where a processor last left straight-line execution. Each cycle the retire stage may report one completed instruction: its address, whether it redirected the instruction stream, and whether it was run as the subject of an Execute instruction. In the Execute case, the retire stage also passes the Execute instruction's own address. The block keeps a 64-bit register that holds the address of the latest instruction that broke sequence. When the redirecting instruction was reached through Execute, the register takes the Execute instruction's address instead of the branch's.

When an interrupt is taken, the block sends the register contents to storage as a single doubleword write at real address 272. It uses a request/acknowledge port for this. The request stays up, with its address and data frozen, until storage acknowledges it. The register keeps tracking retirements while the write is outstanding.

Top module: `break_addr_tracker`

## Requirements
- R1: While reset is high and in the first cycle after it, `last_break` reads zero and `st_req` is low.
- R2: A retirement with `rtr_valid` = 1, `rtr_taken` = 1 and `rtr_via_exec` = 0 makes `last_break` equal `rtr_addr` from the next cycle on.
- R3: A retirement with `rtr_valid` = 1, `rtr_taken` = 1 and `rtr_via_exec` = 1 makes `last_break` equal `rtr_exec_addr`, not `rtr_addr`, from the next cycle on.
- R4: A cycle with `rtr_valid` = 0, or with `rtr_taken` = 0, leaves `last_break` unchanged, whatever the other retire inputs carry.
- R5: `irq_req` high in a cycle when no store is outstanding raises `st_req` in the next cycle. `st_addr` is then 272, and `st_data` is the register value that includes any taken retirement in the same cycle as the request.
- R6: While `st_req` is high and `st_ack` is low, `st_req`, `st_addr` and `st_data` hold their values. In the cycle after `st_ack` is seen high with `st_req`, `st_req` is low.
- R7: `irq_req` in a cycle when a store is outstanding, including the cycle that acknowledges it, starts no further store.
- R8: Taken retirements during an outstanding store update `last_break` normally and do not change `st_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rtr_valid | input | 1 | An instruction completes this cycle |
| rtr_taken | input | 1 | The completing instruction redirected the instruction stream |
| rtr_via_exec | input | 1 | The completing instruction was the subject of an Execute instruction |
| rtr_addr | input | 64 | Address of the completing instruction |
| rtr_exec_addr | input | 64 | Address of the Execute instruction, used when `rtr_via_exec` is 1 |
| irq_req | input | 1 | An interrupt is being taken and the register must be stored |
| st_req | output | 1 | Storage write request |
| st_addr | output | 64 | Real address of the write (272) |
| st_data | output | 64 | Doubleword to write |
| st_ack | input | 1 | Storage accepts the write |
| last_break | output | 64 | Current breaking-event address |

## Verification
The bench targets the following corner cases. In each, a faulty design shows a specific symptom:

- A taken branch that retires in the same cycle as the interrupt request: a design that snapshots the old register stores a stale address.
- Execute-target branches: a design that ignores the substitution records the branch's own address.
- Retirements that are not valid but carry `rtr_taken`: a design that skips the qualification corrupts the register.
- Interrupt requests while a store is outstanding, and in the acknowledge cycle: a design that accepts them issues a second store or drops the pending one.
- Branches during a held store: a design that tracks the live register changes the data under an unacknowledged request.

// File: rtl/bea_pkg.sv
`timescale 1ns/1ps
package bea_pkg;
  typedef enum logic {DUMP_IDLE = 1'b0, DUMP_BUSY = 1'b1} dump_state_t;

  function automatic logic [63:0] pick_src(input logic via_exec,
                                           input logic [63:0] own_addr,
                                           input logic [63:0] exec_addr);
    return via_exec ? exec_addr : own_addr;
  endfunction
endpackage

// File: rtl/bea_capture.sv
`timescale 1ns/1ps
module bea_capture #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic          taken,
  input  logic          via_exec,
  input  logic [AW-1:0] own_addr,
  input  logic [AW-1:0] exec_addr,
  output logic [AW-1:0] last_q,
  output logic [AW-1:0] last_nxt
);
  logic          brk;
  logic [63:0]   src64;

  assign brk   = valid & taken;
  assign src64 = bea_pkg::pick_src(via_exec, 64'(own_addr), 64'(exec_addr));

  always_comb begin
    last_nxt = last_q;
    if (brk) last_nxt = src64[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= '0;
    else     last_q <= last_nxt;
  end

  // Register changes only on a qualified retirement
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(valid && taken) |=> $stable(last_q));

  assert_plain_R2: assert property (@(posedge clk) disable iff (rst)
    (valid && taken && !via_exec) |=> last_q == $past(own_addr));

  assert_exec_R3: assert property (@(posedge clk) disable iff (rst)
    (valid && taken && via_exec) |=> last_q == $past(exec_addr));

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> last_q == '0);
endmodule

// File: rtl/bea_dump.sv
`timescale 1ns/1ps
module bea_dump #(
  parameter int            AW        = 64,
  parameter logic [AW-1:0] DUMP_ADDR = AW'(272)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq_req,
  input  logic [AW-1:0] snap,
  input  logic          ack,
  output logic          req,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] data
);
  import bea_pkg::*;

  dump_state_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= DUMP_IDLE;
      addr <= '0;
      data <= '0;
    end else begin
      case (st_q)
        DUMP_IDLE: if (irq_req) begin
          st_q <= DUMP_BUSY;
          addr <= DUMP_ADDR;
          data <= snap;
        end
        DUMP_BUSY: if (ack) st_q <= DUMP_IDLE;
        default:   st_q <= DUMP_IDLE;
      endcase
    end
  end

  assign req = (st_q == DUMP_BUSY);

  assert_start_R5: assert property (@(posedge clk) disable iff (rst)
    (!req && irq_req) |=> (req && addr == DUMP_ADDR && data == $past(snap)));

  assert_held_R6: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> (req && $stable(addr) && $stable(data)));

  assert_release_R6: assert property (@(posedge clk) disable iff (rst)
    (req && ack) |=> !req);

  assert_noreq_R7: assert property (@(posedge clk) disable iff (rst)
    (!req && !irq_req) |=> !req);

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> !req);
endmodule

// File: rtl/break_addr_tracker.sv
`timescale 1ns/1ps
module break_addr_tracker #(
  parameter int            AW        = 64,
  parameter logic [AW-1:0] DUMP_ADDR = AW'(272)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rtr_valid,
  input  logic          rtr_taken,
  input  logic          rtr_via_exec,
  input  logic [AW-1:0] rtr_addr,
  input  logic [AW-1:0] rtr_exec_addr,
  input  logic          irq_req,
  output logic          st_req,
  output logic [AW-1:0] st_addr,
  output logic [AW-1:0] st_data,
  input  logic          st_ack,
  output logic [AW-1:0] last_break
);
  logic [AW-1:0] nxt;

  bea_capture #(.AW(AW)) u_cap (
    .clk(clk), .rst(rst),
    .valid(rtr_valid), .taken(rtr_taken), .via_exec(rtr_via_exec),
    .own_addr(rtr_addr), .exec_addr(rtr_exec_addr),
    .last_q(last_break), .last_nxt(nxt)
  );

  bea_dump #(.AW(AW), .DUMP_ADDR(DUMP_ADDR)) u_dump (
    .clk(clk), .rst(rst), .irq_req(irq_req), .snap(nxt), .ack(st_ack),
    .req(st_req), .addr(st_addr), .data(st_data)
  );

  // Data of a held store is independent of later branches
  assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    (st_req && !st_ack && rtr_valid && rtr_taken) |=> $stable(st_data));
endmodule

// File: tb/sim_break_addr_tracker.sv
`timescale 1ns/1ps
module sim_break_addr_tracker;
  logic        clk = 1'b0;
  logic        rst;
  logic        rtr_valid, rtr_taken, rtr_via_exec, irq_req, st_ack;
  logic [63:0] rtr_addr, rtr_exec_addr;
  logic        st_req;
  logic [63:0] st_addr, st_data, last_break;

  always #2.5 clk = ~clk;

  break_addr_tracker u0 (
    .clk(clk), .rst(rst), .rtr_valid(rtr_valid), .rtr_taken(rtr_taken),
    .rtr_via_exec(rtr_via_exec), .rtr_addr(rtr_addr), .rtr_exec_addr(rtr_exec_addr),
    .irq_req(irq_req), .st_req(st_req), .st_addr(st_addr), .st_data(st_data),
    .st_ack(st_ack), .last_break(last_break)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [63:0] m_last, m_data;
  bit          m_pend;
  string       tag_reg, tag_st;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] next_last(input logic [63:0] cur, input bit v,
      input bit t, input bit x, input logic [63:0] a, input logic [63:0] ea);
    if (v && t) return x ? ea : a;
    return cur;
  endfunction

  // compare outputs against the model (called at negedge)
  task automatic compare();
    chk(tag_reg, "last_break", last_break, m_last);
    chk(tag_st, "st_req", {63'd0, st_req}, {63'd0, m_pend});
    if (m_pend) begin
      chk(tag_st, "st_addr", st_addr, 64'd272);
      chk(tag_st, "st_data", st_data, m_data);
    end
  endtask

  // apply inputs for next edge and advance the model
  task automatic step(input bit v, input bit t, input bit x, input logic [63:0] a,
                      input logic [63:0] ea, input bit irq, input bit ack);
    logic [63:0] nl;
    rtr_valid = v; rtr_taken = t; rtr_via_exec = x;
    rtr_addr = a; rtr_exec_addr = ea; irq_req = irq; st_ack = ack;
    nl = next_last(m_last, v, t, x, a, ea);
    tag_reg = (v && t) ? (x ? "R3" : "R2") : "R4";
    if (m_pend && ack) begin
      m_pend = 0; tag_st = irq ? "R7" : "R6";
    end else if (!m_pend && irq) begin
      m_pend = 1; m_data = nl; tag_st = "R5";
    end else if (m_pend) begin
      tag_st = (v && t) ? "R8" : (irq ? "R7" : "R6");
    end else tag_st = "R7";
    m_last = nl;
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_init;
    seed_init = $urandom(32'd20240611);
    rst = 1; rtr_valid = 0; rtr_taken = 0; rtr_via_exec = 0;
    rtr_addr = 64'hFFFF_0000_1234_5678; rtr_exec_addr = 64'hAAAA; irq_req = 0; st_ack = 0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1", "last_break in reset", last_break, 64'd0);
    chk("R1", "st_req in reset", {63'd0, st_req}, 64'd0);
    rst = 0;
    m_last = 0; m_pend = 0; m_data = 0; tag_reg = "R1"; tag_st = "R1";
    @(negedge clk);
    compare();

    // R4: taken flag without valid
    step(0, 1, 0, 64'h1111, 64'h2222, 0, 0);
    // R2: plain taken branch
    step(1, 1, 0, 64'h0000_0000_0040_1000, 64'h9, 0, 0);
    // R4: untaken valid instruction
    step(1, 0, 1, 64'h5555, 64'h6666, 0, 0);
    // R3: branch run through Execute
    step(1, 1, 1, 64'h0000_0000_0080_2000, 64'h0000_0000_0070_0100, 0, 0);
    // R5: branch and interrupt in the same cycle
    step(1, 1, 0, 64'hDEAD_BEEF_0000_0010, 64'h0, 1, 0);
    // R7 + R8: irq and branch while pending, no ack
    step(1, 1, 1, 64'h7777, 64'h0000_0000_00AB_CDE0, 1, 0);
    step(0, 0, 0, 64'h0, 64'h0, 0, 0);
    // R7: irq in the ack cycle
    step(0, 0, 0, 64'h0, 64'h0, 1, 1);
    step(0, 0, 0, 64'h0, 64'h0, 0, 0);
    // R5: fresh store with no branch, immediate ack
    step(0, 0, 0, 64'h0, 64'h0, 1, 0);
    step(0, 0, 0, 64'h0, 64'h0, 0, 1);

    for (int i = 0; i < 4000; i++) begin
      bit v, t, x, irq, ack;
      v   = ($urandom % 10) < 7;
      t   = ($urandom % 2) == 1;
      x   = ($urandom % 4) == 0;
      irq = ($urandom % 10) == 0;
      ack = ($urandom % 10) < 4;
      step(v, t, x, {$urandom, $urandom}, {$urandom, $urandom}, irq, ack);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule